// File: doc/BRIEF.md
# Warp Divergence Reconvergence Stack

This block keeps track of which lanes of a SIMD warp take part in each issued instruction while the lanes disagree about a conditional branch. All lanes share one instruction per cycle. When the lanes split on a branch, each lane supplies a predicate bit. The block combines those bits with the lanes that are still live and records the result as the new active set. It also records the point at which the split paths meet again.

Two coupled LIFOs hold this state: one holds lane masks and the other holds reconvergence addresses. Both grow and shrink together. The issue logic reads `active_mask_o` and suppresses the lanes whose bit is clear. A pop happens in two cases: the issued program counter equals the address on top of the target stack, or an explicit join request arrives. Either case restores the enclosing mask. A branch and a pop that arrive in the same cycle are handled pop first, then push. Misuse is reported through sticky overflow and underflow flags.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the stack depth is 0, `active_mask_o` is all ones, and both flags are clear.
- R2: A cycle with `branch_i` high and no pop pushes one entry. From the next cycle, `depth_o` is one higher and `active_mask_o` equals `pred_i & active_mask_o` as sampled in the push cycle.
- R3: Nested branches only remove lanes. A lane whose bit is clear in the enclosing mask stays clear even if its predicate bit is 1.
- R4: When `pc_valid_i` is high, the stack is non-empty and `pc_i` equals the top target, both stacks pop. From the next cycle `active_mask_o` is the entry below, or all ones if the stack is now empty.
- R5: No pop happens when `pc_i` differs from the top target or `pc_valid_i` is low. Depth and mask are unchanged.
- R6: A pop and a branch in the same cycle pop first. The pushed mask is `pred_i` ANDed with the mask restored by the pop, the new target replaces the popped one, and the depth is unchanged.
- R7: A branch while depth equals DEPTH with no pop in the same cycle is dropped. Depth and mask are unchanged, and `overflow_o` rises and stays high until reset.
- R8: `join_i` while the stack is empty leaves the depth at 0 and the mask at all ones, and sets `underflow_o`, which stays high until reset.
- R9: `join_i` on a non-empty stack pops both stacks whatever the value of `pc_i`.
- R10: Pop plus branch while the stack is full does not set `overflow_o`.
- R11: Targets are matched in LIFO order. An outer target presented while an inner one is on top causes no pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| branch_i | input | 1 | Divergent branch: push predicate mask and target |
| pred_i | input | 32 | Per-lane branch predicate bits |
| target_i | input | 32 | Reconvergence address pushed with the mask |
| pc_valid_i | input | 1 | `pc_i` carries the address being issued |
| pc_i | input | 32 | Program counter of the issued instruction |
| join_i | input | 1 | Explicit pop request |
| active_mask_o | output | 32 | Lanes that execute the issued instruction |
| depth_o | output | 4 | Current number of stack entries |
| overflow_o | output | 1 | Sticky: branch dropped on a full stack |
| underflow_o | output | 1 | Sticky: join on an empty stack |

## Verification
The hardest case to reach is a pop and a push in the same cycle on a stack that is already full. Here the restored mask comes from the second entry, and the overflow flag must stay low. The stimulus reaches this state in three steps. It first pushes DEPTH entries, each of which clears one more lane, so that every level has a distinct mask. It then presents the top target together with a new branch. Finally it clears the stack with joins and checks that the overflow flag raised afterwards survives.

// File: rtl/simt_pkg.sv
package simt_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic ovf_set;
    logic udf_set;
  } stk_op_t;
endpackage

// File: rtl/rs_lifo.sv
module rs_lifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [W-1:0]     data_i,
  output logic [W-1:0]     top_o,
  output logic [W-1:0]     below_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q, tip, sub, wr_idx;

  assign tip    = cnt_q - CNT_W'(1);
  assign sub    = cnt_q - CNT_W'(2);
  // pop+push overwrites the popped slot
  assign wr_idx = pop_i ? tip : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_i) mem_q[wr_idx[AW-1:0]] <= data_i;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign top_o   = mem_q[tip[AW-1:0]];
  assign below_o = mem_q[sub[AW-1:0]];
  assign count_o = cnt_q;
endmodule

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import simt_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  parameter int PC_W  = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [PC_W-1:0]  top_tgt_i,
  input  logic [LANES-1:0] top_mask_i,
  input  logic [LANES-1:0] below_mask_i,
  input  logic             branch_i,
  input  logic [LANES-1:0] pred_i,
  input  logic             pc_valid_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             join_i,
  output stk_op_t          op_o,
  output logic [LANES-1:0] push_mask_o,
  output logic [LANES-1:0] cur_mask_o
);
  logic empty, full, hit;
  logic [LANES-1:0] after_pop, base;

  assign empty = (count_i == '0);
  assign full  = (count_i == CNT_W'(DEPTH));
  assign hit   = pc_valid_i && !empty && (pc_i == top_tgt_i);

  always_comb begin
    op_o         = '0;
    op_o.pop     = (hit || join_i) && !empty;
    op_o.udf_set = join_i && empty;
    op_o.push    = branch_i && (!full || op_o.pop);
    op_o.ovf_set = branch_i && full && !op_o.pop;
  end

  assign cur_mask_o  = empty ? '1 : top_mask_i;
  assign after_pop   = (count_i >= CNT_W'(2)) ? below_mask_i : '1;
  assign base        = op_o.pop ? after_pop : cur_mask_o;
  assign push_mask_o = pred_i & base;
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import simt_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  parameter int PC_W  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             branch_i,
  input  logic [LANES-1:0] pred_i,
  input  logic [PC_W-1:0]  target_i,
  input  logic             pc_valid_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             join_i,
  output logic [LANES-1:0] active_mask_o,
  output logic [CNT_W-1:0] depth_o,
  output logic             overflow_o,
  output logic             underflow_o
);
  stk_op_t          op;
  logic [LANES-1:0] mask_top, mask_below, push_mask;
  logic [PC_W-1:0]  tgt_top, tgt_below;
  logic [CNT_W-1:0] mask_cnt, tgt_cnt;
  logic             ovf_q, udf_q;

  rs_lifo #(.W(LANES), .DEPTH(DEPTH), .CNT_W(CNT_W)) mask_stk_i (
    .clk_i, .rst_ni,
    .push_i(op.push), .pop_i(op.pop), .data_i(push_mask),
    .top_o(mask_top), .below_o(mask_below), .count_o(mask_cnt)
  );

  rs_lifo #(.W(PC_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) tgt_stk_i (
    .clk_i, .rst_ni,
    .push_i(op.push), .pop_i(op.pop), .data_i(target_i),
    .top_o(tgt_top), .below_o(tgt_below), .count_o(tgt_cnt)
  );

  rs_ctrl #(.LANES(LANES), .DEPTH(DEPTH), .PC_W(PC_W), .CNT_W(CNT_W)) ctrl_i (
    .count_i(mask_cnt), .top_tgt_i(tgt_top),
    .top_mask_i(mask_top), .below_mask_i(mask_below),
    .branch_i, .pred_i, .pc_valid_i, .pc_i, .join_i,
    .op_o(op), .push_mask_o(push_mask), .cur_mask_o(active_mask_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      if (op.ovf_set) ovf_q <= 1'b1;
      if (op.udf_set) udf_q <= 1'b1;
    end
  end

  assign depth_o     = mask_cnt;
  assign overflow_o  = ovf_q;
  assign underflow_o = udf_q;
endmodule

// File: rtl/rs_reconv_chk.sv
module rs_reconv_chk #(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  parameter int PC_W  = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             branch_i,
  input logic [LANES-1:0] pred_i,
  input logic             pc_valid_i,
  input logic             join_i,
  input logic [LANES-1:0] active_mask_o,
  input logic [CNT_W-1:0] depth_o,
  input logic             overflow_o,
  input logic             underflow_o,
  input logic [CNT_W-1:0] mask_cnt,
  input logic [CNT_W-1:0] tgt_cnt
);
  // R1
  empty_all_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o == '0 |-> active_mask_o == '1);

  // R2
  push_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (branch_i && !join_i && !pc_valid_i && depth_o < CNT_W'(DEPTH)) |=>
      (active_mask_o == ($past(pred_i) & $past(active_mask_o)) &&
       depth_o == $past(depth_o) + CNT_W'(1)));

  // R4
  stacks_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_cnt == tgt_cnt);

  // R7
  no_overflow_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o <= CNT_W'(DEPTH));

  // R7
  overflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  // R8
  underflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);

  // R8
  empty_join_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (join_i && depth_o == '0) |=> (underflow_o && depth_o == '0));
endmodule

bind simt_reconv_stack rs_reconv_chk #(
  .LANES(LANES), .DEPTH(DEPTH), .PC_W(PC_W), .CNT_W(CNT_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .branch_i(branch_i), .pred_i(pred_i),
  .pc_valid_i(pc_valid_i), .join_i(join_i), .active_mask_o(active_mask_o),
  .depth_o(depth_o), .overflow_o(overflow_o), .underflow_o(underflow_o),
  .mask_cnt(mask_cnt), .tgt_cnt(tgt_cnt)
);

// File: tb/simt_reconv_stack_tb.sv
module simt_reconv_stack_tb_top;
  localparam int LANES = 32;
  localparam int DEPTH = 8;
  localparam int PC_W  = 32;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             branch_i = 1'b0;
  logic [LANES-1:0] pred_i = '0;
  logic [PC_W-1:0]  target_i = '0;
  logic             pc_valid_i = 1'b0;
  logic [PC_W-1:0]  pc_i = '0;
  logic             join_i = 1'b0;
  logic [LANES-1:0] active_mask_o;
  logic [3:0]       depth_o;
  logic             overflow_o, underflow_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  simt_reconv_stack #(.LANES(LANES), .DEPTH(DEPTH), .PC_W(PC_W)) dut_i (
    .clk_i(clk), .rst_ni, .branch_i, .pred_i, .target_i, .pc_valid_i,
    .pc_i, .join_i, .active_mask_o, .depth_o, .overflow_o, .underflow_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    branch_i = 0; pred_i = '0; target_i = '0;
    pc_valid_i = 0; pc_i = '0; join_i = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_ni = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
  endtask

  task automatic branch(input logic [31:0] p, input logic [31:0] t);
    branch_i = 1; pred_i = p; target_i = t;
  endtask

  task automatic at_pc(input logic [31:0] a);
    pc_valid_i = 1; pc_i = a;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 depth", 32'(depth_o), 0);
    chk("R1 mask", active_mask_o, 32'hFFFF_FFFF);
    chk("R1 flags", {30'b0, overflow_o, underflow_o}, 0);
  endtask

  task automatic t_push_pop();
    branch(32'h0000_FFFF, 32'h100); step();
    chk("R2 mask", active_mask_o, 32'h0000_FFFF);
    chk("R2 depth", 32'(depth_o), 1);
    at_pc(32'h104); step();
    chk("R5 mismatch depth", 32'(depth_o), 1);
    pc_i = 32'h100; step();
    chk("R5 invalid pc depth", 32'(depth_o), 1);
    chk("R5 mask", active_mask_o, 32'h0000_FFFF);
    at_pc(32'h100); step();
    chk("R4 depth", 32'(depth_o), 0);
    chk("R4 mask", active_mask_o, 32'hFFFF_FFFF);
  endtask

  task automatic t_nested();
    branch(32'hF0F0_F0F0, 32'h200); step();
    branch(32'hFFFF_000F, 32'h180); step();
    chk("R3 mask", active_mask_o, 32'hF0F0_0000);
    at_pc(32'h200); step();
    chk("R11 outer no pop", 32'(depth_o), 2);
    at_pc(32'h180); step();
    chk("R11 inner pop depth", 32'(depth_o), 1);
    chk("R4 restored mask", active_mask_o, 32'hF0F0_F0F0);
    at_pc(32'h200); step();
    chk("R11 outer pop", 32'(depth_o), 0);
  endtask

  task automatic t_pop_push();
    branch(32'h0F0F_0F0F, 32'h300); step();
    at_pc(32'h300); branch(32'h00FF_00FF, 32'h340); step();
    chk("R6 mask single", active_mask_o, 32'h00FF_00FF);
    chk("R6 depth single", 32'(depth_o), 1);
    at_pc(32'h300); step();
    chk("R6 old target gone", 32'(depth_o), 1);
    at_pc(32'h340); step();
    chk("R6 new target", 32'(depth_o), 0);
    branch(32'hAAAA_AAAA, 32'h400); step();
    branch(32'hFFFF_0000, 32'h410); step();
    at_pc(32'h410); branch(32'h0000_FFFF, 32'h420); step();
    chk("R6 mask nested", active_mask_o, 32'h0000_AAAA);
    chk("R6 depth nested", 32'(depth_o), 2);
    join_i = 1; step();
    join_i = 1; step();
    chk("R9 cleared", 32'(depth_o), 0);
  endtask

  task automatic t_join();
    branch(32'h0000_0001, 32'h500); step();
    join_i = 1; at_pc(32'h7FC); step();
    chk("R9 depth", 32'(depth_o), 0);
    chk("R9 mask", active_mask_o, 32'hFFFF_FFFF);
    chk("R9 no underflow", 32'(underflow_o), 0);
  endtask

  task automatic t_underflow();
    join_i = 1; step();
    chk("R8 flag", 32'(underflow_o), 1);
    chk("R8 depth", 32'(depth_o), 0);
    chk("R8 mask", active_mask_o, 32'hFFFF_FFFF);
    step();
    chk("R8 sticky", 32'(underflow_o), 1);
    do_reset();
    chk("R1 underflow cleared", 32'(underflow_o), 0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < DEPTH; i++) begin
      branch(~(32'h1 << i), 32'h1000 + 32'(i)); step();
    end
    chk("R7 full depth", 32'(depth_o), DEPTH);
    chk("R7 full mask", active_mask_o, 32'hFFFF_FF00);
    chk("R7 no flag yet", 32'(overflow_o), 0);
    at_pc(32'h1007); branch(32'hFFFF_FFFF, 32'h2000); step();
    chk("R10 depth", 32'(depth_o), DEPTH);
    chk("R10 mask", active_mask_o, 32'hFFFF_FF80);
    chk("R10 no overflow", 32'(overflow_o), 0);
    branch(32'h0, 32'h3000); step();
    chk("R7 flag", 32'(overflow_o), 1);
    chk("R7 depth kept", 32'(depth_o), DEPTH);
    chk("R7 mask kept", active_mask_o, 32'hFFFF_FF80);
    at_pc(32'h2000); step();
    chk("R7 dropped target", 32'(depth_o), DEPTH - 1);
    for (int i = 0; i < DEPTH - 1; i++) begin
      join_i = 1; step();
    end
    chk("R7 drained", 32'(depth_o), 0);
    chk("R7 sticky", 32'(overflow_o), 1);
    do_reset();
    chk("R1 overflow cleared", 32'(overflow_o), 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    t_reset();
    t_push_pop();
    t_nested();
    t_pop_push();
    t_join();
    t_underflow();
    t_overflow();
    done = 1'b1;
    finish_run();
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule